// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block holds a six-field alarm setting (year, month, day, hour, minute, second) and a field-select mask. On every one-second tick, while the alarm is armed, it compares the alarm setting with the current calendar time presented on its input. Fields whose mask bit is cleared are left out of the comparison. The comparison result is registered one clock after the tick. One clock after that, the match is acted on.

A match is routed one of two ways. When the program-start flag and the storage-checksum-valid flag are both asserted, the block issues a single-cycle start request to an external program interpreter. Otherwise it turns on the pull-down of an open-drain output pin. That pull-down stays on until a release command is received.

After reset, the full mask is in force and the alarm-seconds field holds an impossible value. As a result, no alarm can fire until software has programmed the alarm. The surrounding control logic writes the fields through a simple select/data write port.

Top module: `cal_alarm_top`

## Requirements
- R1: After reset, no start request is issued and the pin pull-down is off. The mask reads as all ones (0xFF). The alarm-seconds field holds 0xFF. All other alarm fields hold 0x00.
- R2: A comparison takes place only on a clock where `tick_i` is high and `arm_i` is high. A time that matches while there is no tick, or while the alarm is disarmed, has no effect.
- R3: Mask bit 0 selects seconds. Bits 1 to 5 select minute, hour, day, month and year, in that order. A field whose mask bit is 0 is ignored in the comparison. Mask bits 6 and 7 have no effect.
- R4: With mask 0x01 and alarm-seconds 0x20, the alarm fires on every tick whose seconds value is 0x20, whatever the minute, hour, day, month and year.
- R5: With the reset mask and the reset alarm values, no in-range time (seconds 0 to 59) ever triggers the alarm.
- R6: Suppose a tick sampled at clock edge E0 produces a match. If `prog_start_i` and `csum_ok_i` are both 1, then `start_req_o` is high for exactly the one cycle after edge E0+1, and the pin pull-down does not change.
- R7: On a match where either of those flags is 0, `pin_pull_o` goes to 1 after edge E0+1. It stays at 1 through later ticks and cycles until a release is received.
- R8: `release_i` high at an edge clears `pin_pull_o` at that edge. If a new match is acted on at the same edge, the pull-down stays on.
- R9: Each write selects its target with `wsel_i`: 0 = seconds, 1 = minute, 2 = hour, 3 = day, 4 = month, 5 = year, 6 = mask. Select 7 writes nothing.
- R10: An unmasked field whose time value differs from its alarm value prevents the trigger. This includes an out-of-range alarm value, such as minute 0x50.
- R11: A single tick produces at most one trigger, which is a single-cycle start request or a single pull-down turn-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| we_i | input | 1 | Register write strobe |
| wsel_i | input | 3 | Write target select (see R9) |
| wdata_i | input | 8 | Write data |
| arm_i | input | 1 | Alarm enable (control bit 6) |
| prog_start_i | input | 1 | Start-on-alarm flag |
| csum_ok_i | input | 1 | Program storage checksum valid |
| tick_i | input | 1 | One-second tick, one clock wide |
| now_i | input | 48 | Current time {year, month, day, hour, minute, second}, seconds in bits 7:0 |
| release_i | input | 1 | Release command: turns the pin pull-down off |
| start_req_o | output | 1 | Single-cycle interpreter start request |
| pin_pull_o | output | 1 | 1 = open-drain pin driven low |

## Verification
On every cycle, the assertions check four things. A registered match always traces back to an armed tick. A start request only ever follows a match taken on the start path. The pull-down holds until it is released, and a lone release always clears it. The two output paths never switch on together.

Some behaviour can only be shown by the bench scenarios, because it depends on values and sequences rather than local cycle relations. These are: the mask bit to field mapping, the reset values that block false triggers, the once-per-minute firing with a seconds-only mask, the silence of an out-of-range alarm field, and the priority of a trigger over a coincident release.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  parameter int unsigned NFIELD = 6;
  parameter int unsigned SELW   = 3;

  typedef enum logic [SELW-1:0] {
    SEL_SEC  = 3'd0,
    SEL_MIN  = 3'd1,
    SEL_HOUR = 3'd2,
    SEL_DAY  = 3'd3,
    SEL_MON  = 3'd4,
    SEL_YEAR = 3'd5,
    SEL_MASK = 3'd6,
    SEL_NONE = 3'd7
  } wsel_e;
endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
  import cal_alarm_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned FW = NFIELD * DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [SELW-1:0] wsel_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [FW-1:0]   alarm_o,
  output logic [NFIELD-1:0] mask_o
);

  // Alarm field storage, seconds (index 0) resets to an impossible value.
  for (genvar g = 0; g < NFIELD; g++) begin : g_fld
    localparam logic [DW-1:0] RV = (g == 0) ? {DW{1'b1}} : {DW{1'b0}};
    logic          fld_en;
    logic [DW-1:0] fld_q;

    always_comb fld_en = we_i && (wsel_i == SELW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      fld_q <= RV;
      else if (fld_en) fld_q <= wdata_i;
    end

    assign alarm_o[g*DW +: DW] = fld_q;
  end

  // Mask storage: only bits that select a field are kept.
  logic              mask_en;
  logic [NFIELD-1:0] mask_q;

  always_comb mask_en = we_i && (wsel_i == SEL_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= {NFIELD{1'b1}};
    else if (mask_en) mask_q <= wdata_i[NFIELD-1:0];
  end

  assign mask_o = mask_q;

  // R9: a mask write lands on the following edge.
  p_mask_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && wsel_i == SEL_MASK) |=> (mask_o == $past(wdata_i[NFIELD-1:0])));

endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned FW = NFIELD * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              arm_i,
  input  logic [FW-1:0]     now_i,
  input  logic [FW-1:0]     alarm_i,
  input  logic [NFIELD-1:0] mask_i,
  output logic              hit_o
);

  logic [NFIELD-1:0] fld_ok;

  // A field agrees when equal or when its mask bit drops it.
  for (genvar g = 0; g < NFIELD; g++) begin : g_cmp
    always_comb
      fld_ok[g] = !mask_i[g] || (now_i[g*DW +: DW] == alarm_i[g*DW +: DW]);
  end

  logic hit_d, hit_q;

  always_comb hit_d = tick_i && arm_i && (&fld_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_d;
  end

  assign hit_o = hit_q;

  // R2: a registered match always follows an armed tick.
  p_hit_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> $past(tick_i && arm_i));

endmodule

// File: rtl/cal_alarm_route.sv
module cal_alarm_route (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic prog_start_i,
  input  logic csum_ok_i,
  input  logic release_i,
  output logic start_req_o,
  output logic pin_pull_o
);

  logic to_prog;
  logic start_d, start_q;
  logic pull_d, pull_q;

  always_comb begin
    to_prog = prog_start_i && csum_ok_i;
    start_d = hit_i && to_prog;
    pull_d  = pull_q;
    if (release_i)          pull_d = 1'b0;
    if (hit_i && !to_prog)  pull_d = 1'b1;  // a trigger outranks a release
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      pull_q  <= 1'b0;
    end else begin
      start_q <= start_d;
      pull_q  <= pull_d;
    end
  end

  assign start_req_o = start_q;
  assign pin_pull_o  = pull_q;

  // R6: a start request comes only from a match on the program path.
  p_start_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_req_o |-> $past(hit_i && prog_start_i && csum_ok_i));

  // R6: the two trigger paths never switch on together.
  p_one_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_pull_o) |-> !start_req_o);

  // R7: the pull-down holds until released.
  p_pull_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pull_o && !release_i) |=> pin_pull_o);

  // R8: a release with no competing match clears the pull-down.
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && !hit_i) |=> !pin_pull_o);

endmodule

// File: rtl/cal_alarm_top.sv
module cal_alarm_top
  import cal_alarm_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned FW = NFIELD * DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [SELW-1:0] wsel_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            arm_i,
  input  logic            prog_start_i,
  input  logic            csum_ok_i,
  input  logic            tick_i,
  input  logic [FW-1:0]   now_i,
  input  logic            release_i,
  output logic            start_req_o,
  output logic            pin_pull_o
);

  // Asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_n_int = rst_sync_q[1];

  logic [FW-1:0]     alarm_w;
  logic [NFIELD-1:0] mask_w;
  logic              hit_w;

  cal_alarm_regs #(.DW(DW)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .we_i    (we_i),
    .wsel_i  (wsel_i),
    .wdata_i (wdata_i),
    .alarm_o (alarm_w),
    .mask_o  (mask_w)
  );

  cal_alarm_match #(.DW(DW)) match_i (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .tick_i  (tick_i),
    .arm_i   (arm_i),
    .now_i   (now_i),
    .alarm_i (alarm_w),
    .mask_i  (mask_w),
    .hit_o   (hit_w)
  );

  cal_alarm_route route_i (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .hit_i        (hit_w),
    .prog_start_i (prog_start_i),
    .csum_ok_i    (csum_ok_i),
    .release_i    (release_i),
    .start_req_o  (start_req_o),
    .pin_pull_o   (pin_pull_o)
  );

endmodule

// File: tb/cal_alarm_top_tb_top.sv
`timescale 1ns/1ps
module cal_alarm_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  wsel = 3'd0;
  logic [7:0]  wdata = 8'd0;
  logic        arm = 1'b0;
  logic        pstart = 1'b0;
  logic        csum = 1'b0;
  logic        tick = 1'b0;
  logic [47:0] now = 48'd0;
  logic        rel = 1'b0;
  logic        start_req;
  logic        pin_pull;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  cal_alarm_top dut_i (
    .clk(clk), .rst_n(rst_n), .we_i(we), .wsel_i(wsel), .wdata_i(wdata),
    .arm_i(arm), .prog_start_i(pstart), .csum_ok_i(csum), .tick_i(tick),
    .now_i(now), .release_i(rel), .start_req_o(start_req), .pin_pull_o(pin_pull)
  );

  function automatic logic [47:0] tm(input logic [7:0] y, mo, d, h, mi, s);
    return {y, mo, d, h, mi, s};
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); we = 1'b1; wsel = s; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  // Tick at edge E0, sample after edge E0+1.
  task automatic tick_at(input logic [47:0] t, output logic s, output logic p);
    @(negedge clk); tick = 1'b1; now = t;
    @(negedge clk); tick = 1'b0;
    @(negedge clk); s = start_req; p = pin_pull;
  endtask

  task automatic do_release;
    @(negedge clk); rel = 1'b1;
    @(negedge clk); rel = 1'b0;
  endtask

  task automatic t_reset;
    logic s, p;
    chk("R1 start idle", start_req, 1'b0);
    chk("R1 pin released", pin_pull, 1'b0);
    arm = 1'b1;
    tick_at(tm(0,0,0,0,0,0), s, p);
    chk("R5 no fire sec 0", p, 1'b0);
    tick_at(tm(0,0,0,0,0,59), s, p);
    chk("R5 no fire sec 59", p, 1'b0);
    wr(3'd6, 8'h3E);            // drop seconds: other fields reset to zero
    tick_at(tm(0,0,0,0,0,17), s, p);
    chk("R1 other fields zero", p, 1'b1);
    do_release;
    chk("R8 release clears", pin_pull, 1'b0);
  endtask

  task automatic t_enable;
    logic s, p;
    wr(3'd6, 8'h01); wr(3'd0, 8'h20);
    arm = 1'b0;
    tick_at(tm(1,2,3,4,5,8'h20), s, p);
    chk("R2 disarmed ignored", p, 1'b0);
    arm = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 no tick no fire", pin_pull, 1'b0);
    tick_at(tm(1,2,3,4,5,8'h20), s, p);
    chk("R2 armed tick fires", p, 1'b1);
    do_release;
  endtask

  task automatic t_minute;
    logic s, p;
    tick_at(tm(9,1,1,1,5,8'h20), s, p);
    chk("R4 minute 5 fires", p, 1'b1);
    do_release;
    tick_at(tm(9,1,1,1,6,8'h21), s, p);
    chk("R4 sec 0x21 silent", p, 1'b0);
    tick_at(tm(77,12,30,23,6,8'h20), s, p);
    chk("R4 other date fires", p, 1'b1);
    do_release;
  endtask

  task automatic t_mask_bits;
    logic s, p;
    logic [47:0] base;
    base = tm(24, 3, 15, 10, 30, 45);
    wr(3'd0, 8'd45); wr(3'd1, 8'd30); wr(3'd2, 8'd10);
    wr(3'd3, 8'd15); wr(3'd4, 8'd3);  wr(3'd5, 8'd24);
    wr(3'd6, 8'h3F);
    tick_at(base, s, p);
    chk("R3 full match fires", p, 1'b1);
    do_release;
    for (int g = 0; g < 6; g++) begin
      logic [47:0] t;
      t = base;
      t[g*8 +: 8] = t[g*8 +: 8] + 8'd1;
      wr(3'd6, 8'hFF);
      tick_at(t, s, p);
      chk("R10 unmasked mismatch blocks", p, 1'b0);
      wr(3'd6, 8'hFF & ~(8'h01 << g));
      tick_at(t, s, p);
      chk("R3 masked field ignored", p, 1'b1);
      do_release;
    end
    wr(3'd6, 8'hC0);
    tick_at(tm(1,1,1,1,1,1), s, p);
    chk("R3 bits 6-7 no effect", p, 1'b1);
    do_release;
  endtask

  task automatic t_out_range;
    logic s, p;
    wr(3'd6, 8'h02); wr(3'd1, 8'h50);
    p = 1'b0;
    for (int m = 0; m < 60; m++) begin
      logic s1, p1;
      tick_at(tm(0,1,1,0,m[7:0],0), s1, p1);
      p = p | p1 | s1;
    end
    chk("R10 out-of-range minute never fires", p, 1'b0);
  endtask

  task automatic t_route;
    logic s, p;
    int n;
    wr(3'd6, 8'h01); wr(3'd0, 8'd7);
    pstart = 1'b1; csum = 1'b1;
    tick_at(tm(0,0,0,0,0,7), s, p);
    chk("R6 start pulse", s, 1'b1);
    chk("R6 pin untouched", p, 1'b0);
    @(negedge clk);
    chk("R11 pulse one cycle", start_req, 1'b0);
    n = 0;
    @(negedge clk); tick = 1'b1; now = tm(0,0,0,0,1,7);
    @(negedge clk); tick = 1'b0;
    for (int i = 0; i < 5; i++) begin
      if (start_req) n++;
      @(negedge clk);
    end
    chk("R11 one pulse per tick", n == 1, 1'b1);
    csum = 1'b0;
    tick_at(tm(0,0,0,0,2,7), s, p);
    chk("R7 bad checksum pulls", p, 1'b1);
    chk("R7 no start", s, 1'b0);
    do_release;
    pstart = 1'b0; csum = 1'b1;
    tick_at(tm(0,0,0,0,3,7), s, p);
    chk("R7 flag off pulls", p, 1'b1);
    tick_at(tm(0,0,0,0,3,8), s, p);
    repeat (5) @(negedge clk);
    chk("R7 held low", pin_pull, 1'b1);
    do_release;
    chk("R8 released", pin_pull, 1'b0);
  endtask

  task automatic t_release_race;
    @(negedge clk); tick = 1'b1; now = tm(0,0,0,0,4,7);
    @(negedge clk); tick = 1'b0; rel = 1'b1;
    @(negedge clk); rel = 1'b0;
    chk("R8 trigger beats release", pin_pull, 1'b1);
    do_release;
  endtask

  task automatic t_sel7;
    logic s, p;
    wr(3'd7, 8'h00);
    tick_at(tm(0,0,0,0,5,8), s, p);
    chk("R9 sel 7 writes nothing", p, 1'b0);
    tick_at(tm(0,0,0,0,5,7), s, p);
    chk("R9 sel 0 is seconds", p, 1'b1);
    do_release;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_enable;
    t_minute;
    t_mask_bits;
    t_out_range;
    t_route;
    t_release_race;
    t_sel7;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule